// File: doc/BRIEF.md
# Cycle-Steal Display Memory Arbiter

This block lets a host processor and a display refresh fetcher share one single-port display memory of 19200 bytes, organised as 16-bit words. Time is cut into pairs of main-clock cycles. In each pair the first cycle is a host slot and the second a fetch slot. While the display is in its active line-transfer period, cycle stealing is on: the host is held to its slot, and a host request that arrives in a fetch slot is stalled with an active-low wait signal for one clock. During the horizontal idle period the host is served in any cycle without a stall. A fetch is served in the next fetch slot that the host does not use.

The host side decodes byte lanes for either a 16-bit or an 8-bit host. It checks every host address against the size of the memory. Out-of-range writes are dropped and out-of-range reads return zero. Fetched words are handed to the display side in a byte order chosen by a swap input. A status output shows whether cycle stealing is on.

Top module: `ca_cycle_steal_arb`

## Requirements
- R1: Slots alternate from reset release: the first cycle after reset is a host slot (even), the next a fetch slot (odd), and so on. While stealing is active, host memory operations occur only in host slots and fetches only in fetch slots.
- R2: `hst_wait_n` is driven low in the same cycle as an unserved host request (`hst_sel_n`=0 together with `hst_rd_n`=0, `hst_wrl_n`=0 or `hst_wrh_n`=0) only when stealing is active and the cycle is a fetch slot. It is high in every other case.
- R3: `hst_wait_n` is never low for two consecutive clocks. A stalled request is served in the following host slot.
- R4: While stealing is inactive, a host request is served in the cycle it first appears, with no wait.
- R5: `steal_active_o` equals `disp_active_i` delayed by one clock.
- R6: With `hst_bus16`=1, the word is `hst_addr[14:1]`. The low byte lane is enabled when `hst_addr[0]`=0, and the high lane when `hst_bhe_n`=0. A write changes only enabled lanes. A read returns the enabled lanes, with disabled lanes as zero.
- R7: With `hst_bus16`=0, `hst_addr` is a byte address. Bit 0 set selects the high byte of the word. Writes take `hst_wdata[7:0]`. Reads return the byte on `hst_rdata[7:0]` with the upper byte as zero.
- R8: Read data appears on `hst_rdata` two clocks after the serving cycle and holds until the next read is served.
- R9: Byte addresses above 0x4AFF are out of range. Writes to them change no memory and issue no memory operation. Reads from them return zero. Wait is released normally. 0x4AFE/0x4AFF remain accessible.
- R10: A fetch request on `disp_req_i` is latched and served in a later fetch slot not used by the host. `disp_valid_o` pulses two clocks after the serving cycle with the word on `disp_data_o`. Bits [15:8] hold the byte shown first: the memory's upper byte when `disp_swap_i`=0 and its lower byte when it is 1.
- R11: While `rst_n` is low, at a clock edge `hst_wait_n`=1 and `steal_active_o`=0. `disp_valid_o` and `hst_rdata` are 0.
- R12: A host strobe held over several cycles is served exactly once. Later changes of write data during the same strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_sel_n | input | 1 | Host memory select, active low |
| hst_rd_n | input | 1 | Host read strobe, active low |
| hst_wrl_n | input | 1 | Host low write strobe, active low |
| hst_wrh_n | input | 1 | Host high write strobe, active low |
| hst_bhe_n | input | 1 | Host high-byte enable, active low (16-bit mode) |
| hst_bus16 | input | 1 | 1 = 16-bit host, 0 = 8-bit host |
| hst_addr | input | 15 | Host byte address |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data |
| hst_wait_n | output | 1 | Host stall, active low |
| disp_active_i | input | 1 | Active display transfer period |
| disp_req_i | input | 1 | Fetch request pulse |
| disp_addr_i | input | 14 | Fetch word address |
| disp_swap_i | input | 1 | Display byte order select |
| disp_valid_o | output | 1 | Fetched word valid |
| disp_data_o | output | 16 | Fetched word in display order |
| steal_active_o | output | 1 | Cycle stealing in effect |
| mem_en_o | output | 1 | Memory operation enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_be_o | output | 2 | Memory byte-lane enables |
| mem_addr_o | output | 14 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, one clock after enable |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that a host holds its strobe until it sees wait high at a clock edge, then releases it for at least one clock before the next access. A further assumption is that the fetcher does not pulse a new request while one is still pending. The bench keeps to this. It issues one host access at a time with a released cycle in between, and it spaces fetch requests until the previous word has come back. It also moves host requests between even and odd cycle alignments, so that both the stalled and the unstalled paths are reached under active stealing.

// File: rtl/ca_pkg.sv
// Shared types for the cycle-steal arbiter.
package ca_pkg;
    // Slot owner within the two-clock basic cycle
    typedef enum logic {
        SLOT_HOST  = 1'b0,
        SLOT_FETCH = 1'b1
    } slot_e;

    // Context of a served host read, carried to the data-return stage
    typedef struct packed {
        logic       pend;
        logic       bus16;
        logic [1:0] be;
        logic       in_range;
    } rdctx_t;
endpackage

// File: rtl/ca_slot_timer.sv
// Slot timer: alternates host/fetch slots from reset release and registers
// the active-display flag into the cycle-steal state.
// Assumes disp_active_i is synchronous to clk.
module ca_slot_timer
    import ca_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  disp_active_i,
    output slot_e slot_o,
    output logic  steal_o
);
    slot_e slot_q;
    logic  steal_q;

    // Toggle slot owner each clock; sample the display period flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q  <= SLOT_HOST;
            steal_q <= 1'b0;
        end else begin
            slot_q  <= (slot_q == SLOT_HOST) ? SLOT_FETCH : SLOT_HOST;
            steal_q <= disp_active_i;
        end
    end

    assign slot_o  = slot_q;
    assign steal_o = steal_q;
endmodule

// File: rtl/ca_host_decode.sv
// Host address decoder: word address, byte lanes, write-data steering and
// range check for 8-bit and 16-bit hosts. Purely combinational.
// Assumes the memory holds MEM_WORDS words of two bytes each.
module ca_host_decode #(
    parameter  int ADDR_W    = 15,
    parameter  int DATA_W    = 16,
    parameter  int MEM_WORDS = 9600,
    localparam int WORD_AW   = $clog2(MEM_WORDS),
    localparam int BYTE_W    = DATA_W / 2
) (
    input  logic               bus16_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               bhe_n_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [WORD_AW-1:0] word_addr_o,
    output logic [1:0]         be_o,
    output logic [DATA_W-1:0]  wdata_o,
    output logic               in_range_o
);
    localparam logic [ADDR_W-2:0] LAST_WORD = (ADDR_W-1)'(MEM_WORDS - 1);

    logic [ADDR_W-2:0] word_full;

    // Split byte address into word index and lane controls
    always_comb begin
        word_full   = addr_i[ADDR_W-1:1];
        in_range_o  = (word_full <= LAST_WORD);
        word_addr_o = word_full[WORD_AW-1:0];
        if (bus16_i) begin
            be_o    = {~bhe_n_i, ~addr_i[0]};
            wdata_o = wdata_i;
        end else begin
            be_o    = {addr_i[0], ~addr_i[0]};
            wdata_o = {2{wdata_i[BYTE_W-1:0]}};
        end
    end
endmodule

// File: rtl/ca_fetch_port.sv
// Fetch port: latches a display fetch request until a slot serves it, then
// returns the word two clocks after service in the selected byte order.
// Assumes memory read data is valid one clock after the enable.
module ca_fetch_port #(
    parameter  int WORD_AW = 14,
    parameter  int DATA_W  = 16,
    localparam int BYTE_W  = DATA_W / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic [WORD_AW-1:0] addr_i,
    input  logic               served_i,
    input  logic               swap_i,
    input  logic [DATA_W-1:0]  mem_rdata_i,
    output logic               pend_o,
    output logic [WORD_AW-1:0] addr_o,
    output logic               valid_o,
    output logic [DATA_W-1:0]  data_o
);
    logic               pend_q;
    logic [WORD_AW-1:0] addr_q;
    logic               served_q;
    logic               valid_q;
    logic [DATA_W-1:0]  data_q;

    // Hold the pending request until a fetch slot serves it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            addr_q <= '0;
        end else if (req_i) begin
            pend_q <= 1'b1;
            addr_q <= addr_i;
        end else if (served_i) begin
            pend_q <= 1'b0;
        end
    end

    // Capture returned word, ordering bytes for display
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            served_q <= 1'b0;
            valid_q  <= 1'b0;
            data_q   <= '0;
        end else begin
            served_q <= served_i;
            valid_q  <= served_q;
            if (served_q) begin
                data_q <= swap_i ? {mem_rdata_i[BYTE_W-1:0], mem_rdata_i[DATA_W-1:BYTE_W]}
                                 : mem_rdata_i;
            end
        end
    end

    assign pend_o  = pend_q;
    assign addr_o  = addr_q;
    assign valid_o = valid_q;
    assign data_o  = data_q;
endmodule

// File: rtl/ca_cycle_steal_arb.sv
// Cycle-steal arbiter: shares a single-port display memory between a host
// port and a display fetcher using two-clock basic cycles. Stalls the host
// only while cycle stealing is active. Assumes synchronous inputs, a
// memory with one-clock read latency, and a host that releases its strobe
// between accesses.
module ca_cycle_steal_arb
    import ca_pkg::*;
#(
    parameter  int ADDR_W    = 15,
    parameter  int DATA_W    = 16,
    parameter  int MEM_BYTES = 19200,
    localparam int MEM_WORDS = MEM_BYTES / 2,
    localparam int WORD_AW   = $clog2(MEM_WORDS),
    localparam int BYTE_W    = DATA_W / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hst_sel_n,
    input  logic               hst_rd_n,
    input  logic               hst_wrl_n,
    input  logic               hst_wrh_n,
    input  logic               hst_bhe_n,
    input  logic               hst_bus16,
    input  logic [ADDR_W-1:0]  hst_addr,
    input  logic [DATA_W-1:0]  hst_wdata,
    output logic [DATA_W-1:0]  hst_rdata,
    output logic               hst_wait_n,
    input  logic               disp_active_i,
    input  logic               disp_req_i,
    input  logic [WORD_AW-1:0] disp_addr_i,
    input  logic               disp_swap_i,
    output logic               disp_valid_o,
    output logic [DATA_W-1:0]  disp_data_o,
    output logic               steal_active_o,
    output logic               mem_en_o,
    output logic               mem_we_o,
    output logic [1:0]         mem_be_o,
    output logic [WORD_AW-1:0] mem_addr_o,
    output logic [DATA_W-1:0]  mem_wdata_o,
    input  logic [DATA_W-1:0]  mem_rdata_i
);
    slot_e              slot;
    logic               steal;
    logic [WORD_AW-1:0] h_word;
    logic [1:0]         h_be;
    logic [DATA_W-1:0]  h_wdata;
    logic               h_in_range;
    logic               f_pend;
    logic [WORD_AW-1:0] f_addr;
    logic               host_req;
    logic               host_wr;
    logic               host_slot_ok;
    logic               host_grant;
    logic               fetch_grant;
    logic               done_q;
    rdctx_t             ctx_q;
    logic [DATA_W-1:0]  rdata_q;
    logic [DATA_W-1:0]  rd_masked;

    ca_slot_timer u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .disp_active_i (disp_active_i),
        .slot_o        (slot),
        .steal_o       (steal)
    );

    ca_host_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .MEM_WORDS (MEM_WORDS)
    ) u_dec (
        .bus16_i     (hst_bus16),
        .addr_i      (hst_addr),
        .bhe_n_i     (hst_bhe_n),
        .wdata_i     (hst_wdata),
        .word_addr_o (h_word),
        .be_o        (h_be),
        .wdata_o     (h_wdata),
        .in_range_o  (h_in_range)
    );

    ca_fetch_port #(
        .WORD_AW (WORD_AW),
        .DATA_W  (DATA_W)
    ) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (disp_req_i),
        .addr_i      (disp_addr_i),
        .served_i    (fetch_grant),
        .swap_i      (disp_swap_i),
        .mem_rdata_i (mem_rdata_i),
        .pend_o      (f_pend),
        .addr_o      (f_addr),
        .valid_o     (disp_valid_o),
        .data_o      (disp_data_o)
    );

    // Slot allocation and host stall decision
    always_comb begin
        host_req     = ~hst_sel_n & (~hst_rd_n | ~hst_wrl_n | ~hst_wrh_n);
        host_wr      = ~hst_wrl_n | ~hst_wrh_n;
        host_slot_ok = ~steal | (slot == SLOT_HOST);
        host_grant   = host_req & ~done_q & host_slot_ok;
        fetch_grant  = f_pend & (slot == SLOT_FETCH) & ~host_grant;
        hst_wait_n   = ~(host_req & ~done_q & ~host_slot_ok);
    end

    // Drive the memory port from whichever side owns this cycle
    always_comb begin
        mem_en_o    = (host_grant & h_in_range) | fetch_grant;
        mem_we_o    = host_grant & h_in_range & host_wr;
        mem_addr_o  = host_grant ? h_word : f_addr;
        mem_be_o    = host_grant ? h_be : 2'b11;
        mem_wdata_o = h_wdata;
    end

    // Mask returned word to the lanes the served read asked for
    always_comb begin
        if (!ctx_q.in_range) begin
            rd_masked = '0;
        end else if (ctx_q.bus16) begin
            rd_masked = {ctx_q.be[1] ? mem_rdata_i[DATA_W-1:BYTE_W] : {BYTE_W{1'b0}},
                         ctx_q.be[0] ? mem_rdata_i[BYTE_W-1:0]      : {BYTE_W{1'b0}}};
        end else begin
            rd_masked = {{BYTE_W{1'b0}},
                         ctx_q.be[1] ? mem_rdata_i[DATA_W-1:BYTE_W] : mem_rdata_i[BYTE_W-1:0]};
        end
    end

    // Track served strobes and return host read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            ctx_q   <= '0;
            rdata_q <= '0;
        end else begin
            done_q         <= host_req & (done_q | host_grant);
            ctx_q.pend     <= host_grant & ~host_wr;
            ctx_q.bus16    <= hst_bus16;
            ctx_q.be       <= h_be;
            ctx_q.in_range <= h_in_range;
            if (ctx_q.pend) begin
                rdata_q <= rd_masked;
            end
        end
    end

    assign hst_rdata      = rdata_q;
    assign steal_active_o = steal;
endmodule

// File: rtl/ca_arb_chk.sv
// Checker for the cycle-steal arbiter, bound into every instance.
// Assumes synchronous inputs and a host that releases strobes between accesses.
module ca_arb_chk #(
    parameter int WORD_AW   = 14,
    parameter int MEM_WORDS = 9600
) (
    input logic               clk,
    input logic               rst_n,
    input logic               slot_i,
    input logic               steal_active_o,
    input logic               disp_active_i,
    input logic               host_req,
    input logic               host_grant,
    input logic               fetch_grant,
    input logic               hst_wait_n,
    input logic               mem_en_o,
    input logic [WORD_AW-1:0] mem_addr_o,
    input logic               disp_valid_o
);
    localparam logic [WORD_AW-1:0] LAST_W = WORD_AW'(MEM_WORDS - 1);

    // R1
    host_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (steal_active_o && host_grant) |-> (slot_i == 1'b0));

    // R1
    fetch_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_grant |-> (slot_i == 1'b1));

    // R2
    wait_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hst_wait_n |-> (steal_active_o && slot_i && host_req));

    // R4
    idle_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !steal_active_o) |-> hst_wait_n);

    // R3
    wait_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hst_wait_n |=> hst_wait_n);

    // R5
    steal_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (steal_active_o == $past(disp_active_i)));

    // R9
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en_o |-> (mem_addr_o <= LAST_W));

    // R10
    fetch_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_grant |-> ##2 disp_valid_o);

    // R12
    single_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_grant |=> !host_grant);
endmodule

bind ca_cycle_steal_arb ca_arb_chk #(
    .WORD_AW   (WORD_AW),
    .MEM_WORDS (MEM_WORDS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .slot_i         (slot),
    .steal_active_o (steal_active_o),
    .disp_active_i  (disp_active_i),
    .host_req       (host_req),
    .host_grant     (host_grant),
    .fetch_grant    (fetch_grant),
    .hst_wait_n     (hst_wait_n),
    .mem_en_o       (mem_en_o),
    .mem_addr_o     (mem_addr_o),
    .disp_valid_o   (disp_valid_o)
);

// File: tb/tb_ca_cycle_steal_arb.sv
`timescale 1ns/1ps
module tb_ca_cycle_steal_arb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_sel_n = 1'b1, hst_rd_n = 1'b1, hst_wrl_n = 1'b1, hst_wrh_n = 1'b1;
    logic        hst_bhe_n = 1'b1, hst_bus16 = 1'b1;
    logic [14:0] hst_addr = '0;
    logic [15:0] hst_wdata = '0;
    logic [15:0] hst_rdata;
    logic        hst_wait_n;
    logic        disp_active_i = 1'b0, disp_req_i = 1'b0, disp_swap_i = 1'b0;
    logic [13:0] disp_addr_i = '0;
    logic        disp_valid_o;
    logic [15:0] disp_data_o;
    logic        steal_active_o;
    logic        mem_en_o, mem_we_o;
    logic [1:0]  mem_be_o;
    logic [13:0] mem_addr_o;
    logic [15:0] mem_wdata_o;
    logic [15:0] mem_rdata_i = '0;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    ca_cycle_steal_arb dut (
        .clk(clk), .rst_n(rst_n),
        .hst_sel_n(hst_sel_n), .hst_rd_n(hst_rd_n), .hst_wrl_n(hst_wrl_n),
        .hst_wrh_n(hst_wrh_n), .hst_bhe_n(hst_bhe_n), .hst_bus16(hst_bus16),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .hst_wait_n(hst_wait_n), .disp_active_i(disp_active_i),
        .disp_req_i(disp_req_i), .disp_addr_i(disp_addr_i), .disp_swap_i(disp_swap_i),
        .disp_valid_o(disp_valid_o), .disp_data_o(disp_data_o),
        .steal_active_o(steal_active_o), .mem_en_o(mem_en_o), .mem_we_o(mem_we_o),
        .mem_be_o(mem_be_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i)
    );

    // Behavioural memory with one-clock read latency
    logic [15:0] bmem [int];
    logic [15:0] bm_word;
    always @(posedge clk) begin
        if (mem_en_o) begin
            bm_word = bmem.exists(int'(mem_addr_o)) ? bmem[int'(mem_addr_o)] : 16'h0;
            mem_rdata_i <= bm_word;
            if (mem_we_o) begin
                if (mem_be_o[0]) bm_word[7:0]  = mem_wdata_o[7:0];
                if (mem_be_o[1]) bm_word[15:8] = mem_wdata_o[15:8];
                bmem[int'(mem_addr_o)] = bm_word;
            end
        end
    end

    // Reference byte store, updated from the requirements
    logic [7:0] rb [int];
    function automatic logic [7:0] rbyte(int a);
        return rb.exists(a) ? rb[a] : 8'h00;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Cycle reference model of slot parity, stealing and served strobes
    int m_cycle = 0;
    bit m_steal = 1'b0;
    bit m_done  = 1'b0;
    function automatic bit m_req();
        return !hst_sel_n && (!hst_rd_n || !hst_wrl_n || !hst_wrh_n);
    endfunction
    function automatic bit m_wait_n();
        bit slot_ok = !m_steal || (m_cycle % 2 == 0);
        return !(m_req() && !m_done && !slot_ok);
    endfunction
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cycle = 0; m_steal = 1'b0; m_done = 1'b0;
        end else begin
            if (!m_req()) m_done = 1'b0;
            else if (m_wait_n()) m_done = 1'b1;
            m_steal = disp_active_i;
            m_cycle++;
        end
    end
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            chk(hst_wait_n == m_wait_n(), "R2 wait per clock", 32'(hst_wait_n), 32'(m_wait_n()));
            chk(steal_active_o == m_steal, "R5 steal flag", 32'(steal_active_o), 32'(m_steal));
        end
    end

    task automatic host_op(input bit wr, input bit b16, input logic [14:0] a,
                           input logic bhe_n, input logic [15:0] wd,
                           output int waits, output logic [15:0] rd);
        int w;
        @(negedge clk);
        hst_bus16 = b16; hst_addr = a; hst_bhe_n = bhe_n; hst_wdata = wd;
        hst_sel_n = 1'b0;
        if (wr) hst_wrl_n = 1'b0; else hst_rd_n = 1'b0;
        waits = 0;
        #1;
        while (!hst_wait_n) begin
            waits++;
            @(negedge clk); #1;
        end
        @(posedge clk);
        @(negedge clk);
        hst_sel_n = 1'b1; hst_rd_n = 1'b1; hst_wrl_n = 1'b1;
        rd = '0;
        if (wr && a <= 15'h4AFF) begin
            w = int'(a) & ~1;
            if (b16) begin
                if (!a[0]) rb[w] = wd[7:0];
                if (!bhe_n) rb[w+1] = wd[15:8];
            end else begin
                rb[int'(a)] = wd[7:0];
            end
        end
        if (!wr) begin
            @(negedge clk); #1;
            rd = hst_rdata;
        end
    endtask

    function automatic logic [15:0] exp_read(bit b16, logic [14:0] a, logic bhe_n);
        int w = int'(a) & ~1;
        if (a > 15'h4AFF) return 16'h0;
        if (b16) return {!bhe_n ? rbyte(w+1) : 8'h0, !a[0] ? rbyte(w) : 8'h0};
        return {8'h0, rbyte(int'(a))};
    endfunction

    task automatic fetch(input logic [13:0] wa, input bit sw, output bit got, output logic [15:0] d);
        @(negedge clk);
        disp_req_i = 1'b1; disp_addr_i = wa; disp_swap_i = sw;
        @(negedge clk);
        disp_req_i = 1'b0;
        got = 1'b0; d = '0;
        for (int i = 0; i < 5 && !got; i++) begin
            #1;
            if (disp_valid_o) begin got = 1'b1; d = disp_data_o; end
            else @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(5 * 100000);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int wt, maxw, anyw;
        logic [15:0] d, e;
        bit got;

        repeat (3) @(negedge clk);
        #1;
        // R11 reset state
        chk(hst_wait_n == 1'b1, "R11 wait", 32'(hst_wait_n), 1);
        chk(steal_active_o == 1'b0, "R11 steal", 32'(steal_active_o), 0);
        chk(disp_valid_o == 1'b0, "R11 valid", 32'(disp_valid_o), 0);
        chk(hst_rdata == 16'h0, "R11 rdata", 32'(hst_rdata), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4 R6 idle word write and read
        host_op(1, 1, 15'h0010, 1'b0, 16'hA55A, wt, d);
        chk(wt == 0, "R4 idle write no wait", wt, 0);
        host_op(0, 1, 15'h0010, 1'b0, 16'h0, wt, d);
        chk(wt == 0, "R4 idle read no wait", wt, 0);
        chk(d == 16'hA55A, "R6 R8 word read", d, 16'hA55A);
        // R6 high lane only, then low lane only read
        host_op(1, 1, 15'h0011, 1'b0, 16'h77EE, wt, d);
        host_op(0, 1, 15'h0010, 1'b0, 16'h0, wt, d);
        chk(d == exp_read(1, 15'h0010, 1'b0), "R6 high lane write", d, exp_read(1, 15'h0010, 1'b0));
        host_op(0, 1, 15'h0010, 1'b1, 16'h0, wt, d);
        chk(d == 16'h005A, "R6 low lane read", d, 16'h005A);

        // R7 8-bit host
        host_op(1, 0, 15'h0021, 1'b1, 16'hFF3C, wt, d);
        host_op(1, 0, 15'h0020, 1'b1, 16'hFFC3, wt, d);
        host_op(0, 0, 15'h0021, 1'b1, 16'h0, wt, d);
        chk(d == 16'h003C, "R7 odd byte read", d, 16'h003C);
        host_op(0, 1, 15'h0020, 1'b0, 16'h0, wt, d);
        chk(d == 16'h3CC3, "R7 bytes in word", d, 16'h3CC3);

        // R9 range boundary
        host_op(1, 1, 15'h4AFE, 1'b0, 16'h1234, wt, d);
        host_op(0, 1, 15'h4AFE, 1'b0, 16'h0, wt, d);
        chk(d == 16'h1234, "R9 last word", d, 16'h1234);
        host_op(1, 1, 15'h4B00, 1'b0, 16'hFFFF, wt, d);
        chk(wt <= 1, "R9 wait released", wt, 1);
        host_op(0, 1, 15'h4B00, 1'b0, 16'h0, wt, d);
        chk(d == 16'h0, "R9 out of range read", d, 0);
        host_op(0, 1, 15'h4AFE, 1'b0, 16'h0, wt, d);
        chk(d == 16'h1234, "R9 neighbour intact", d, 16'h1234);

        // R10 fetch byte order
        fetch(14'h0008, 1'b0, got, d);
        e = {rbyte(16'h11), rbyte(16'h10)};
        chk(got && d == e, "R10 fetch no swap", d, e);
        fetch(14'h0008, 1'b1, got, d);
        e = {rbyte(16'h10), rbyte(16'h11)};
        chk(got && d == e, "R10 fetch swap", d, e);

        // R5 R2 R3 active stealing
        @(negedge clk);
        disp_active_i = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk(steal_active_o == 1'b1, "R5 steal on", 32'(steal_active_o), 1);
        maxw = 0; anyw = 0;
        for (int i = 0; i < 6; i++) begin
            if (i % 2 == 1) @(negedge clk);
            host_op(0, 1, 15'h0010, 1'b0, 16'h0, wt, d);
            if (wt > maxw) maxw = wt;
            if (wt > 0) anyw++;
            chk(d == exp_read(1, 15'h0010, 1'b0), "R1 active read data", d, exp_read(1, 15'h0010, 1'b0));
        end
        chk(maxw <= 1, "R3 wait at most one clock", maxw, 1);
        chk(anyw > 0, "R2 wait seen while stealing", anyw, 1);
        // R1 host and fetch together under stealing
        fork
            host_op(1, 1, 15'h0040, 1'b0, 16'hBEEF, wt, d);
            fetch(14'h0010, 1'b0, got, e);
        join
        chk(got && e == {rbyte(16'h21), rbyte(16'h20)}, "R1 fetch beside host", e, {rbyte(16'h21), rbyte(16'h20)});
        host_op(0, 1, 15'h0040, 1'b0, 16'h0, wt, d);
        chk(d == 16'hBEEF, "R1 host write beside fetch", d, 16'hBEEF);
        @(negedge clk);
        disp_active_i = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(steal_active_o == 1'b0, "R5 steal off", 32'(steal_active_o), 0);

        // R12 held strobe served once
        @(negedge clk);
        hst_bus16 = 1'b1; hst_addr = 15'h0030; hst_bhe_n = 1'b0; hst_wdata = 16'h1111;
        hst_sel_n = 1'b0; hst_wrl_n = 1'b0;
        @(negedge clk);
        hst_wdata = 16'h2222;
        repeat (3) @(negedge clk);
        hst_sel_n = 1'b1; hst_wrl_n = 1'b1;
        rb[16'h30] = 8'h11; rb[16'h31] = 8'h11;
        host_op(0, 1, 15'h0030, 1'b0, 16'h0, wt, d);
        chk(d == 16'h1111, "R12 held strobe once", d, 16'h1111);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule